// File: doc/BRIEF.md
# Three-Channel Compare-Match Timer with Interrupts

The block keeps one free-running main counter and three compare channels that watch it. Software programs each channel through a memory-mapped register port: a configuration register and a comparator value register. When the running counter equals a channel's comparator value, the channel sets its bit in a shared interrupt status register. If that channel's interrupt is enabled, it also drives its own interrupt output.

Each channel signals in one of two ways. In edge mode every match gives a one-cycle pulse. In level mode the output is held until software clears the status bit by writing a one to it. Channel 0 alone can run periodically: after each match its comparator advances by the last value software wrote to it, so matches repeat at a fixed interval. Channels 1 and 2 are one-shot only.

The register port is a flat 64-bit read/write interface with no byte lanes. Reads are combinational from the address. Writes take effect on the rising clock edge on which the write strobe is high.

Top module: `cmp_timer_top`

## Requirements
- R1: The main counter (offset 0x0F0, read/write) increases by one on each clock while bit 0 of the control register (offset 0x010) is 1, and holds its value while that bit is 0. A write to 0x0F0 loads the counter. After reset the counter is 0 and bit 0 is 0.
- R2: Each channel configuration register is at 0x100 + 0x20*n. Bit 1 selects level mode (1) or edge mode (0), bit 2 enables the interrupt, and bit 3 selects periodic mode. Every other bit reads 0, and after reset the register reads 0.
- R3: In channels 1 and 2, bit 3 of the configuration register always reads 0, and writing it changes neither the readback nor the behaviour.
- R4: When the counter is running and equals a channel's comparator, bit n of the status register (offset 0x020) becomes 1 from the next clock on.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A match in the same cycle as a clear wins. After reset the status register reads 0.
- R6: In edge mode with the interrupt enabled, each match drives the channel's interrupt output high for exactly one cycle, starting the cycle after the match.
- R7: In level mode with the interrupt enabled, the interrupt output is high while the channel's status bit is set. A further match before the clear keeps it high, and clearing the status bit drops it.
- R8: With the interrupt enable bit at 0, a match still sets the status bit, but the channel's interrupt output stays low.
- R9: With periodic mode set on channel 0, every match adds the last value written to the comparator register onto the comparator, so the matches repeat at that interval.
- R10: The comparator register of channel n is at 0x108 + 0x20*n. It reads back its current value and is all ones after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 12 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr`, combinational |
| irq | output | 3 | One interrupt output per channel |

## Verification
Some properties are checked by assertions on every cycle. The counter steps by one while running and holds while stopped. A match always sets its status bit, and a one-write with no competing match clears it. A level-mode output follows its pending status bit. A channel whose interrupt is disabled stays silent.

Other behaviour is checked only by the bench's scenarios:
- the single-cycle width and exact timing of edge pulses;
- the count of periodic matches and the comparator value they leave behind;
- the reserved and hard-wired configuration bits;
- the level output staying high through a second match before it is cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_W       = 64;
  localparam int unsigned OFS_CTRL    = 'h010;
  localparam int unsigned OFS_STATUS  = 'h020;
  localparam int unsigned OFS_COUNT   = 'h0F0;
  localparam int unsigned OFS_CH_BASE = 'h100;
  localparam int unsigned CH_STRIDE   = 'h020;
  localparam int unsigned OFS_CH_CMP  = 'h008;
  // configuration field positions
  localparam int unsigned BIT_LEVEL   = 1;
  localparam int unsigned BIT_IE      = 2;
  localparam int unsigned BIT_PERIOD  = 3;

  typedef struct packed {
    logic periodic;
    logic ie;
    logic level;
  } ch_cfg_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr_main_counter.sv
module tmr_main_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = ld | run;
    if (ld) cnt_d = ld_val;
    else    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W        = 64,
  parameter bit          PERIODIC_CAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run,
  input  logic             cfg_we,
  input  logic             cmp_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             status_bit,
  output logic [REG_W-1:0] cfg_rd,
  output logic [REG_W-1:0] cmp_rd,
  output ch_cfg_t          cfg,
  output logic             match,
  output logic             irq
);
  logic             level_q, level_d;
  logic             ie_q, ie_d;
  logic             periodic;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] step_q, step_d;
  logic             edge_q, edge_d;

  // periodic capability chosen per channel
  generate
    if (PERIODIC_CAP) begin : g_per
      logic per_q, per_d;
      always_comb per_d = cfg_we ? wdata[BIT_PERIOD] : per_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      per_q <= 1'b0;
        else if (cfg_we) per_q <= per_d;
      end
      assign periodic = per_q;
    end else begin : g_oneshot
      assign periodic = 1'b0;
    end
  endgenerate

  assign match = run && (cnt == cmp_q);

  always_comb begin
    level_d = cfg_we ? wdata[BIT_LEVEL] : level_q;
    ie_d    = cfg_we ? wdata[BIT_IE]    : ie_q;
    step_d  = cmp_we ? wdata[CNT_W-1:0] : step_q;
    if (cmp_we)                 cmp_d = wdata[CNT_W-1:0];
    else if (match && periodic) cmp_d = cmp_q + step_q;
    else                        cmp_d = cmp_q;
    edge_d = match && ie_q && !level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      ie_q    <= 1'b0;
    end else if (cfg_we) begin
      level_q <= level_d;
      ie_q    <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      step_q <= '0;
    end else begin
      if (cmp_we || (match && periodic)) cmp_q <= cmp_d;
      if (cmp_we)                        step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= edge_d;
  end

  assign irq = edge_q | (level_q & ie_q & status_bit);

  assign cfg.periodic = periodic;
  assign cfg.ie       = ie_q;
  assign cfg.level    = level_q;

  always_comb begin
    cfg_rd = '0;
    cfg_rd[BIT_LEVEL]  = level_q;
    cfg_rd[BIT_IE]     = ie_q;
    cfg_rd[BIT_PERIOD] = periodic;
    cmp_rd = REG_W'(cmp_q);
  end
endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status #(
  parameter int unsigned N_CH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] match,
  input  logic            clr_we,
  input  logic [N_CH-1:0] clr_mask,
  output logic [N_CH-1:0] status
);
  logic [N_CH-1:0] sts_q, sts_d, clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
    sts_d   = (sts_q & ~clr_eff) | match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign status = sts_q;
endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH          = 3,
  parameter int unsigned CNT_W         = 64,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned PERIODIC_MASK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [N_CH-1:0]   irq
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);

  function automatic logic [ADDR_W-1:0] cfg_addr(input int unsigned ch);
    return ADDR_W'(OFS_CH_BASE + ch * CH_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_addr(input int unsigned ch);
    return ADDR_W'(OFS_CH_BASE + ch * CH_STRIDE + OFS_CH_CMP);
  endfunction

  logic             rst_sync_n;
  logic             run_q, run_d, run_we;
  logic             cnt_we, sts_we;
  logic [CNT_W-1:0] cnt_q;
  logic [N_CH-1:0]  sts_q, ch_match, ch_lvl, ch_ie;
  logic [REG_W-1:0] cfg_rd [N_CH];
  logic [REG_W-1:0] cmp_rd [N_CH];
  ch_cfg_t          ch_cfg [N_CH];

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    run_we = wr_en && (addr == A_CTRL);
    cnt_we = wr_en && (addr == A_COUNT);
    sts_we = wr_en && (addr == A_STATUS);
    run_d  = run_we ? wdata[0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else if (run_we) run_q <= run_d;
  end

  tmr_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (run_q),
    .ld     (cnt_we),
    .ld_val (wdata[CNT_W-1:0]),
    .cnt    (cnt_q)
  );

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic cfg_we_i, cmp_we_i;
      assign cfg_we_i = wr_en && (addr == cfg_addr(i));
      assign cmp_we_i = wr_en && (addr == cmp_addr(i));

      tmr_channel #(
        .CNT_W        (CNT_W),
        .PERIODIC_CAP (((PERIODIC_MASK >> i) & 1) != 0)
      ) u_ch (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .cnt        (cnt_q),
        .run        (run_q),
        .cfg_we     (cfg_we_i),
        .cmp_we     (cmp_we_i),
        .wdata      (wdata),
        .status_bit (sts_q[i]),
        .cfg_rd     (cfg_rd[i]),
        .cmp_rd     (cmp_rd[i]),
        .cfg        (ch_cfg[i]),
        .match      (ch_match[i]),
        .irq        (irq[i])
      );

      assign ch_lvl[i] = ch_cfg[i].level;
      assign ch_ie[i]  = ch_cfg[i].ie;
    end
  endgenerate

  tmr_irq_status #(.N_CH(N_CH)) u_sts (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .match    (ch_match),
    .clr_we   (sts_we),
    .clr_mask (wdata[N_CH-1:0]),
    .status   (sts_q)
  );

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)   rdata = REG_W'(run_q);
    if (addr == A_STATUS) rdata = REG_W'(sts_q);
    if (addr == A_COUNT)  rdata = REG_W'(cnt_q);
    for (int unsigned i = 0; i < N_CH; i++) begin
      if (addr == cfg_addr(i)) rdata = cfg_rd[i];
      if (addr == cmp_addr(i)) rdata = cmp_rd[i];
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned N_CH  = 3,
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CH-1:0]  irq,
  input logic [N_CH-1:0]  status,
  input logic [N_CH-1:0]  lvl,
  input logic [N_CH-1:0]  ie,
  input logic [N_CH-1:0]  match,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic             cnt_ld,
  input logic             clr_we,
  input logic [N_CH-1:0]  clr_mask
);
  // R1
  counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cnt_ld |=> cnt == $past(cnt) + CNT_W'(1));

  // R1
  counter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_ld |=> $stable(cnt));

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_chk
      // R4
      match_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match[i] |=> status[i]);

      // R5
      clear_drops_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && clr_mask[i] && !match[i] |=> !status[i]);

      // R7
      level_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl[i] && ie[i] && status[i] |-> irq[i]);

      // R8
      masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie[i] && $past(!ie[i]) |-> !irq[i]);
    end
  endgenerate
endmodule

bind cmp_timer_top tmr_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq      (irq),
  .status   (sts_q),
  .lvl      (ch_lvl),
  .ie       (ch_ie),
  .match    (ch_match),
  .cnt      (cnt_q),
  .run      (run_q),
  .cnt_ld   (cnt_we),
  .clr_we   (sts_we),
  .clr_mask (wdata[N_CH-1:0])
);

// File: tb/tb_cmp_timer_top.sv
module tb_cmp_timer_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h010, A_STS = 12'h020, A_CNT = 12'h0F0;
  localparam logic [11:0] A_CFG0 = 12'h100, A_CMP0 = 12'h108;
  localparam logic [11:0] A_CFG1 = 12'h120, A_CMP1 = 12'h128;
  localparam logic [11:0] A_CFG2 = 12'h140, A_CMP2 = 12'h148;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [11:0] a;
    logic [63:0] wd;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  // write, then read back the same offset
  localparam vec_t VEC [8] = '{
    '{a: 12'h100, wd: 64'hFFFF_FFFF_FFFF_FFFF, exp: 64'hE,      req: 8'd2},  // R2 reserved bits
    '{a: 12'h120, wd: 64'hF,                   exp: 64'h6,      req: 8'd3},  // R3 ch1 type bit
    '{a: 12'h140, wd: 64'h8,                   exp: 64'h0,      req: 8'd3},  // R3 ch2 type bit
    '{a: 12'h128, wd: 64'h1234,                exp: 64'h1234,   req: 8'd10}, // R10 comparator
    '{a: 12'h0F0, wd: 64'h77,                  exp: 64'h77,     req: 8'd1},  // R1 counter load
    '{a: 12'h100, wd: 64'h8,                   exp: 64'h8,      req: 8'd9},  // R9 ch0 type bit
    '{a: 12'h020, wd: 64'h7,                   exp: 64'h0,      req: 8'd5},  // R5 nothing pending
    '{a: 12'h100, wd: 64'h0,                   exp: 64'h0,      req: 8'd2}   // R2
  };

  logic        clk, rst_n, wr_en;
  logic [11:0] addr;
  logic [63:0] wdata, rdata;
  logic [2:0]  irq;
  int          n_tests, n_fail;

  cmp_timer_top dut (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // all tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // run counter for n cycles, counting high samples and pulses on one irq
  task automatic run_watch(input int n, input int ch, output int highs, output int pulses,
                           output int maxw);
    int w;
    logic prev;
    highs = 0; pulses = 0; maxw = 0; w = 0; prev = 1'b0;
    wr(A_CTRL, 64'h1);
    for (int i = 0; i < n; i++) begin
      if (irq[ch]) begin
        highs++; w++;
        if (!prev) pulses++;
        if (w > maxw) maxw = w;
      end else w = 0;
      prev = irq[ch];
      @(negedge clk);
    end
    wr(A_CTRL, 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int hi, pu, mw;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd(A_CFG0, v);  check("R2 cfg0 reset", v, 64'h0);
    rd(A_CMP0, v);  check("R10 cmp0 reset", v, ONES);
    rd(A_STS, v);   check("R5 status reset", v, 64'h0);
    rd(A_CNT, v);   check("R1 counter reset", v, 64'h0);
    check("R6 irq reset", 64'(irq), 64'h0);

    // R1 counting and holding
    run_watch(10, 0, hi, pu, mw);
    rd(A_CNT, v);   check("R1 counter after run", v, 64'd11);
    repeat (3) @(negedge clk);
    rd(A_CNT, v);   check("R1 counter holds", v, 64'd11);

    // register vector table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i].a, VEC[i].wd);
      rd(VEC[i].a, v);
      check($sformatf("R%0d table %0d", VEC[i].req, i), v, VEC[i].exp);
    end
    wr(A_CFG1, 64'h0); wr(A_CFG2, 64'h0); wr(A_CMP1, ONES);

    // R6 edge mode, one-shot, match at 5
    wr(A_CMP0, 64'd5); wr(A_CFG0, 64'h4); wr(A_CNT, 64'h0);
    run_watch(23, 0, hi, pu, mw);
    check("R6 edge pulse count", 64'(pu), 64'd1);
    check("R6 edge pulse width", 64'(mw), 64'd1);
    rd(A_STS, v);   check("R4 status set by match", v, 64'h1);
    rd(A_CMP0, v);  check("R10 one-shot comparator unchanged", v, 64'd5);
    rd(A_CNT, v);   check("R1 counter after edge run", v, 64'd24);
    wr(A_STS, 64'h0);
    rd(A_STS, v);   check("R5 zero write keeps status", v, 64'h1);
    wr(A_STS, 64'h1);
    rd(A_STS, v);   check("R5 one write clears status", v, 64'h0);

    // R9 periodic, interval 5
    wr(A_CFG0, 64'hC); wr(A_CMP0, 64'd5); wr(A_CNT, 64'h0);
    run_watch(23, 0, hi, pu, mw);
    check("R9 periodic pulse count", 64'(pu), 64'd4);
    check("R9 periodic pulse width", 64'(mw), 64'd1);
    rd(A_CMP0, v);  check("R9 comparator advanced", v, 64'd25);
    wr(A_STS, 64'h7); wr(A_CFG0, 64'h0);

    // R3 type bit on ch1 does not make it periodic
    wr(A_CFG1, 64'hC); wr(A_CMP1, 64'd2); wr(A_CNT, 64'h0);
    run_watch(10, 1, hi, pu, mw);
    rd(A_CMP1, v);  check("R3 ch1 comparator stays", v, 64'd2);
    check("R3 ch1 single pulse", 64'(pu), 64'd1);
    wr(A_STS, 64'h7);

    // R7 level mode on ch1, match at 3
    wr(A_CMP1, 64'd3); wr(A_CFG1, 64'h6); wr(A_CNT, 64'h0);
    run_watch(10, 1, hi, pu, mw);
    check("R7 level high cycles", 64'(hi), 64'd6);
    check("R7 level held after stop", 64'(irq[1]), 64'h1);
    wr(A_CNT, 64'h0);
    run_watch(10, 1, hi, pu, mw);
    check("R7 level held through second match", 64'(hi), 64'd10);
    wr(A_STS, 64'h2);
    check("R7 level dropped by clear", 64'(irq[1]), 64'h0);
    rd(A_STS, v);   check("R5 ch1 cleared", v, 64'h0);
    wr(A_CFG1, 64'h0); wr(A_CMP1, ONES);

    // R8 interrupt disabled on ch2, level mode
    wr(A_CMP2, 64'd2); wr(A_CFG2, 64'h2); wr(A_CNT, 64'h0);
    run_watch(8, 2, hi, pu, mw);
    check("R8 masked irq stays low", 64'(hi), 64'd0);
    check("R8 masked irq low after run", 64'(irq[2]), 64'h0);
    rd(A_STS, v);   check("R8 status still set", v, 64'h4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule